// File: doc/BRIEF.md
# Chip Scan Firewall

This block sits at a chip's external test port. It decides whether a debugger sees a single protective bypass bit or the chip's internal test controllers chained in series. After power-up the port shows only a one-bit bypass register, in both data and instruction scans. The internal controllers meanwhile receive a forced, constant mode-select input, so stray activity on the pins during a hot plug cannot move them. This keeps a long chain short: each chip in this state adds only one bit.

An external tracker counts zero-bit data scans and reports a locked control level. When the chip's own state follower reaches Update-DR with level 2 locked, a lowering command is armed. Level 3 arms raising in the same way. An armed command takes effect only on a clock edge taken in Run-Test/Idle with TMS low. At that edge the internal controllers are given the real TMS, so their state lines up with the chip-level state.

Every step of the sequence is ordinary state-machine traffic, so plain boundary-scan devices on the same chain see nothing unusual. The internal controllers are outside the block.

Top module: `chip_scan_firewall`

## Requirements
- R1: While reset is held and right after it, tap_freeze is all ones, tap_tms is all ones and tdo is 0.
- R2: With the firewall up, a data scan sees one bit: it is loaded with 0 on the Capture-DR edge, takes TDI on each Shift-DR edge, and drives tdo. Shifting in an 8-bit pattern p, taken LSB first, returns {p[6:0],0}.
- R3: With the firewall up, an instruction scan also sees one bit: it is loaded with 1 on the Capture-IR edge and then shifted from TDI.
- R4: Before the first lowering, frozen controllers get TMS fixed at 1, so they stay in Test-Logic-Reset. After a later raise they get TMS fixed at 0, so they stay in Run-Test/Idle, even while the port walks to Test-Logic-Reset.
- R5: Reaching Update-DR with ctl_locked high arms a lowering when ctl_level is 2 and a raising when it is 3. The armed change is applied on the first edge in Run-Test/Idle with TMS 0, and at that edge tap_tms already equals tms. An edge in Run-Test/Idle with TMS 1 does not apply it.
- R6: Update-DR with ctl_locked low, or with any level other than 2 or 3, leaves the firewall unchanged.
- R7: While a command is armed and not yet applied, scans keep using the old path and tap_freeze keeps its value.
- R8: With the firewall down, tap_tdi[0] = tdi, tap_tdi[1] = tap_tdo[0], tdo = tap_tdo[1], tap_tms equals tms, and tap_freeze is all zeros.
- R9: Entering Test-Logic-Reset discards an armed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tms | input | 1 | Mode select from the port pin |
| tdi | input | 1 | Serial data from the port pin |
| ctl_level | input | 3 | Control level reported by the tracker |
| ctl_locked | input | 1 | Tracker reports the level as locked |
| tap_tdo | input | 2 | Serial outputs of internal controllers 0 and 1 |
| tdo | output | 1 | Serial data to the port pin |
| tap_tdi | output | 2 | Serial inputs to the internal controllers |
| tap_tms | output | 2 | Gated mode select per internal controller |
| tap_freeze | output | 2 | High while the controller is held frozen |

## Verification
The hardest case to reach is a command that is armed but still waiting. To get there, the stimulus leaves Update-DR with TMS high, runs a full data scan straight from Select-DR, and returns to Run-Test/Idle. It then passes once through that state with TMS high. Only after that does it allow the edge that applies the command. The bench checks at every stop that the one-bit path is still in place. A modelled pair of controllers, with capture values 3'b101 and 5'b10011, shows whether the frozen units kept their state through the switch. It also shows that they line up with the port at the switching edge.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_e;

  function automatic tap_st_e tap_next(tap_st_e s, logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: return m ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: return m ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
      default:   return TS_RESET;
    endcase
  endfunction

endpackage

// File: rtl/tap_state_tracker.sv
module tap_state_tracker
  import fw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_e state
);

  tap_st_e st_q, st_d;

  always_comb begin
    st_d = tap_next(st_q, tms);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_RESET;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/bypass_cell.sv
module bypass_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_dr,
  input  logic cap_ir,
  input  logic shift_en,
  input  logic din,
  output logic q
);

  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (cap_dr)        q_d = 1'b0;
    else if (cap_ir)   q_d = 1'b1;
    else if (shift_en) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R2
  cap_dr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_dr) |-> !q_q);
  // R3
  cap_ir_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_ir) |-> q_q);
  // R2
  shift_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_en) |-> (q_q == $past(din)));

endmodule

// File: rtl/firewall_ctrl.sv
module firewall_ctrl
  import fw_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int LOWER_LVL = 2,
  parameter int RAISE_LVL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tap_st_e          state,
  input  logic             tms,
  input  logic [LVL_W-1:0] ctl_level,
  input  logic             ctl_locked,
  output logic             down,
  output logic             go,
  output logic             frozen_tms
);

  localparam logic [LVL_W-1:0] LOWER_CODE = LVL_W'(LOWER_LVL);
  localparam logic [LVL_W-1:0] RAISE_CODE = LVL_W'(RAISE_LVL);

  logic in_upd, in_rti, in_tlr, cmd_lower, cmd_raise;
  logic pend_q, pend_d, tgt_q, tgt_d, down_q, down_d, been_q, been_d;

  assign in_upd    = (state == TS_UPD_DR);
  assign in_rti    = (state == TS_IDLE);
  assign in_tlr    = (state == TS_RESET);
  assign cmd_lower = ctl_locked && (ctl_level == LOWER_CODE);
  assign cmd_raise = ctl_locked && (ctl_level == RAISE_CODE);

  always_comb begin
    pend_d = pend_q;
    tgt_d  = tgt_q;
    down_d = down_q;
    been_d = been_q;
    go     = pend_q && in_rti && !tms;
    if (go) begin
      down_d = tgt_q;
      pend_d = 1'b0;
      if (tgt_q) been_d = 1'b1;
    end
    if (in_tlr) begin
      pend_d = 1'b0;
    end else if (in_upd && (cmd_lower || cmd_raise)) begin
      pend_d = 1'b1;
      tgt_d  = cmd_lower;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      down_q <= 1'b0;
      been_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      down_q <= down_d;
      been_q <= been_d;
    end
  end

  assign down       = down_q;
  assign frozen_tms = !been_q;

  // R5
  switch_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (down_q != $past(down_q)) |-> $past(in_rti && !tms));
  // R9
  tlr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_tlr) |-> !pend_q);

endmodule

// File: rtl/chip_scan_firewall.sv
module chip_scan_firewall
  import fw_pkg::*;
#(
  parameter int N_TAPS      = 2,
  parameter int LVL_W       = 3,
  parameter int LOWER_LVL   = 2,
  parameter int RAISE_LVL   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [LVL_W-1:0]  ctl_level,
  input  logic              ctl_locked,
  input  logic [N_TAPS-1:0] tap_tdo,
  output logic              tdo,
  output logic [N_TAPS-1:0] tap_tdi,
  output logic [N_TAPS-1:0] tap_tms,
  output logic [N_TAPS-1:0] tap_freeze
);

  localparam int LAST = N_TAPS - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic    rst_n;
  tap_st_e state;
  logic    byp_q, down, go, frozen_tms, pass_tms;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = sync_q[SYNC_STAGES-1];

  tap_state_tracker u_track (
    .clk   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  bypass_cell u_byp (
    .clk      (tck),
    .rst_n    (rst_n),
    .cap_dr   (state == TS_CAP_DR),
    .cap_ir   (state == TS_CAP_IR),
    .shift_en ((state == TS_SHF_DR) || (state == TS_SHF_IR)),
    .din      (tdi),
    .q        (byp_q)
  );

  firewall_ctrl #(
    .LVL_W     (LVL_W),
    .LOWER_LVL (LOWER_LVL),
    .RAISE_LVL (RAISE_LVL)
  ) u_ctrl (
    .clk        (tck),
    .rst_n      (rst_n),
    .state      (state),
    .tms        (tms),
    .ctl_level  (ctl_level),
    .ctl_locked (ctl_locked),
    .down       (down),
    .go         (go),
    .frozen_tms (frozen_tms)
  );

  assign pass_tms = down || go;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    if (i == 0) begin : g_head
      assign tap_tdi[i] = tdi;
    end else begin : g_link
      assign tap_tdi[i] = tap_tdo[i-1];
    end
    assign tap_tms[i]    = pass_tms ? tms : frozen_tms;
    assign tap_freeze[i] = !down;
  end

  assign tdo = down ? tap_tdo[LAST] : byp_q;

  // R4
  frozen_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(!down && !go) && !down && !go) |-> $stable(tap_tms));

endmodule

// File: tb/chip_scan_firewall_tb_top.sv
`timescale 1ns/1ps
module chip_scan_firewall_tb_top;

  logic       tck = 1'b0;
  logic       trst_n, tms, tdi, ctl_locked;
  logic [2:0] ctl_level;
  logic [1:0] tap_tdo, tap_tdi, tap_tms, tap_freeze;
  logic       tdo;

  int n_chk = 0, n_fail = 0;

  always #2 tck = ~tck;

  chip_scan_firewall dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .ctl_level(ctl_level), .ctl_locked(ctl_locked), .tap_tdo(tap_tdo),
    .tdo(tdo), .tap_tdi(tap_tdi), .tap_tms(tap_tms), .tap_freeze(tap_freeze)
  );

  // Internal controller models: 0 = reset, 1 = idle, 3 = capture-DR, 4 = shift-DR
  localparam int          LEN [2] = '{3, 5};
  localparam logic [7:0]  CAP [2] = '{8'h05, 8'h13};
  int         m_st [2];
  logic [7:0] m_reg [2];

  function automatic int nxt(int s, logic m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!trst_n) begin
        m_st[i]  <= 0;
        m_reg[i] <= 8'h00;
      end else begin
        if (m_st[i] == 3)      m_reg[i] <= CAP[i];
        else if (m_st[i] == 4) m_reg[i] <= (m_reg[i] >> 1) | (8'(tap_tdi[i]) << (LEN[i] - 1));
        m_st[i] <= nxt(m_st[i], tap_tms[i]);
      end
    end
  end

  assign tap_tdo[0] = m_reg[0][0];
  assign tap_tdo[1] = m_reg[1][0];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; o is tdo before the rising edge.
  task automatic step(input logic t, input logic d, output logic o);
    o = tdo;
    tms = t;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic dr_scan(input int n, input logic [15:0] din, output logic [15:0] dout,
                         input bit from_sel, input bit to_rti);
    logic o;
    dout = '0;
    if (!from_sel) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k], o);
      dout[k] = o;
    end
    step(1'b1, 1'b0, o);
    step(!to_rti, 1'b0, o);
  endtask

  task automatic ir_scan(input int n, input logic [15:0] din, output logic [15:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k], o);
      dout[k] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic zbs(input bit to_rti);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(!to_rti, 1'b0, o);
  endtask

  // {pattern in, expected out} for the one-bit bypass path
  localparam logic [15:0] VEC [4] = '{16'hA5_4A, 16'hFF_FE, 16'h00_00, 16'h3C_78};

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] out;
    logic o;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; ctl_locked = 1'b0; ctl_level = 3'd0;
    repeat (3) @(negedge tck);
    chk("R1 freeze in reset", 32'(tap_freeze), 32'h3);
    chk("R1 tms in reset", 32'(tap_tms), 32'h3);
    trst_n = 1'b1;
    repeat (3) @(negedge tck);
    chk("R1 freeze after reset", 32'(tap_freeze), 32'h3);
    chk("R1 tdo after reset", 32'(tdo), 32'h0);
    step(1'b0, 1'b0, o);

    for (int v = 0; v < 4; v++) begin
      dr_scan(8, {8'h00, VEC[v][15:8]}, out, 1'b0, 1'b1);
      chk("R2 bypass data scan", 32'(out[7:0]), 32'(VEC[v][7:0]));
    end
    chk("R4 tap0 held in reset", m_st[0], 0);
    chk("R4 tap1 held in reset", m_st[1], 0);

    ir_scan(4, 16'h0, out);
    chk("R3 ir capture one", 32'(out[3:0]), 32'h1);
    ir_scan(4, 16'hF, out);
    chk("R3 ir shift", 32'(out[3:0]), 32'hF);

    // R6: wrong level, then right level but unlocked
    ctl_locked = 1'b1; ctl_level = 3'd4;
    zbs(1'b1);
    step(1'b0, 1'b0, o);
    chk("R6 level 4 ignored", 32'(tap_freeze), 32'h3);
    ctl_locked = 1'b0; ctl_level = 3'd2;
    zbs(1'b1);
    step(1'b0, 1'b0, o);
    dr_scan(8, 16'hA5, out, 1'b0, 1'b1);
    chk("R6 unlocked ignored", 32'(out[7:0]), 32'h4A);

    // R9: armed, then Test-Logic-Reset
    ctl_locked = 1'b1;
    zbs(1'b0);
    ctl_locked = 1'b0;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk("R9 armed command dropped", 32'(tap_freeze), 32'h3);

    // R7 and R5: arm lowering, scan on the old path, then apply
    ctl_locked = 1'b1;
    zbs(1'b0);
    ctl_locked = 1'b0;
    dr_scan(8, 16'h3C, out, 1'b1, 1'b1);
    chk("R7 old path while armed", 32'(out[7:0]), 32'h78);
    chk("R7 still frozen", 32'(tap_freeze), 32'h3);
    step(1'b1, 1'b0, o);
    chk("R5 idle with tms high not applied", 32'(tap_freeze), 32'h3);
    step(1'b0, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk("R5 lowered", 32'(tap_freeze), 32'h0);
    chk("R5 tap0 synced to idle", m_st[0], 1);
    chk("R5 tap1 synced to idle", m_st[1], 1);

    dr_scan(8, 16'h00, out, 1'b0, 1'b1);
    chk("R8 series chain", 32'(out[7:0]), 32'hB3);
    step(1'b1, 1'b0, o);
    chk("R8 tms passes", 32'(tap_tms), 32'h3);
    chk("R8 link", 32'(tap_tdi[1]), 32'(tap_tdo[0]));
    step(1'b0, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    dr_scan(8, 16'hFF, out, 1'b0, 1'b1);
    chk("R8 series chain again", 32'(out[7:0]), 32'hB3);

    // Raise again with level 3
    ctl_locked = 1'b1; ctl_level = 3'd3;
    zbs(1'b1);
    ctl_locked = 1'b0;
    chk("R7 down path kept while armed", 32'(tap_freeze), 32'h0);
    step(1'b0, 1'b0, o);
    chk("R5 raised", 32'(tap_freeze), 32'h3);
    chk("R4 frozen tms low after lowering", 32'(tap_tms), 32'h0);
    dr_scan(8, 16'hA5, out, 1'b0, 1'b1);
    chk("R2 bypass after raise", 32'(out[7:0]), 32'h4A);
    chk("R4 tap0 held in idle", m_st[0], 1);
    repeat (5) step(1'b1, 1'b0, o);
    chk("R4 tap1 idle through port reset", m_st[1], 1);
    chk("R4 tms held low", 32'(tap_tms), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule